// File: doc/BRIEF.md
# Signal Register Event Decoder

This block is the slave-side receive register that another bus master writes to when it wants to signal this node. Only a 16-bit write to configuration byte offset 8 is taken. The word uses the 16-bit status/ID layout: the low byte holds the logical address of the sender, and the upper byte says whether the word is a response or an event. For an event, the upper byte also says which event it is.

Each accepted write is decoded when it arrives and stored as one entry. The entry holds the raw word, a kind code, the user event code and the sender address. The entry goes out on a valid/ready port, and `evt_valid` also serves as the local interrupt line. Local logic takes the entry by raising `evt_ready` while `evt_valid` is high.

The write side cannot be stalled, because a remote master cannot be held off. It is therefore a plain strobe with no ready. Back-pressure on the output port is handled as follows:
- The entry and `evt_valid` stay unchanged for as long as `evt_ready` is low.
- A write that finds the entry still held is discarded, and it sets a sticky overflow flag.
- A write that arrives in the same cycle the entry is released is kept.

Top module: `sig_event_decoder`

## Requirements
- R1: After reset, `evt_valid` and `ovf_flag` are 0.
- R2: A write is taken only when `wr_en`=1, `wr_wide`=1 and `wr_addr`=8. Any other write has no effect on the outputs.
- R3: A taken write appears on `evt_word` with `evt_valid`=1 on the cycle after the write. Word and valid then hold steady while `evt_ready` is 0.
- R4: When bit 15 of the word is 0, `evt_kind` is 0 (response).
- R5: When bit 15 is 1, the upper byte selects a standard event. 0xFF gives kind 1 (no cause given), 0xFD gives kind 2 (request true) and 0xFC gives kind 3 (request false).
- R6: Bit 15 = 1 with bit 14 = 0 gives kind 4 (user event), and `evt_user_code` carries bits 13..8. For every other kind, `evt_user_code` is 0.
- R7: Any other word with bit 15 set gives kind 5 (other event).
- R8: `evt_sender` equals bits 7..0 of the stored word.
- R9: A cycle with `evt_valid`=1 and `evt_ready`=1 releases the entry, so `evt_valid` is 0 on the next cycle unless a new write is taken.
- R10: A taken-address write that arrives while the entry is held and not released sets `ovf_flag`. The new word is discarded. `ovf_flag` then stays 1 until reset.
- R11: A write in the same cycle as a release is stored as the new entry, and it does not set `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus slave logic |
| wr_addr | input | 6 | Configuration byte offset of the write |
| wr_wide | input | 1 | 1 when the access is 16 bits wide |
| wr_data | input | 16 | Written word |
| evt_valid | output | 1 | Entry present; local interrupt |
| evt_ready | input | 1 | Local logic takes the entry |
| evt_word | output | 16 | Stored raw word |
| evt_kind | output | 3 | Decoded kind code (0..5) |
| evt_user_code | output | 6 | User event code, 0 unless kind 4 |
| evt_sender | output | 8 | Logical address of the sender |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `evt_ready` is a level sampled only with `evt_valid`, and that a write strobe lasts one cycle per bus write. The stimulus raises each strobe and each ready pulse for exactly one clock, driven away from the active edge. The sweeps cover every upper-byte value and every offset and width combination of the write port. Overflow is provoked only after all other checks, because it is sticky. A second reset is applied before the same-cycle release case.

// File: rtl/sigreg_pkg.sv
package sigreg_pkg;
  localparam int WORD_W  = 16;
  localparam int LA_W    = 8;
  localparam int UCODE_W = 6;

  typedef enum logic [2:0] {
    K_RESPONSE  = 3'd0,
    K_NO_CAUSE  = 3'd1,
    K_REQ_TRUE  = 3'd2,
    K_REQ_FALSE = 3'd3,
    K_USER      = 3'd4,
    K_OTHER     = 3'd5
  } sig_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0]  word;
    sig_kind_e          kind;
    logic [UCODE_W-1:0] ucode;
  } sig_entry_t;
endpackage

// File: rtl/sig_addr_match.sv
module sig_addr_match #(
  parameter int ADDR_W = 6,
  parameter int OFFSET = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] OFS = OFFSET[ADDR_W-1:0];
  assign hit = wr_en && wr_wide && (wr_addr == OFS);
endmodule

// File: rtl/sig_word_decode.sv
module sig_word_decode
  import sigreg_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output sig_entry_t        entry
);
  localparam int HI_LSB = LA_W;
  logic [7:0] hi;
  assign hi = word[WORD_W-1:HI_LSB];

  always_comb begin
    entry.word  = word;
    entry.ucode = '0;
    if (!word[15])            entry.kind = K_RESPONSE;
    else if (hi == 8'hFF)     entry.kind = K_NO_CAUSE;
    else if (hi == 8'hFD)     entry.kind = K_REQ_TRUE;
    else if (hi == 8'hFC)     entry.kind = K_REQ_FALSE;
    else if (!word[14]) begin
      entry.kind  = K_USER;
      entry.ucode = word[HI_LSB+UCODE_W-1:HI_LSB];
    end
    else                      entry.kind = K_OTHER;
  end
endmodule

// File: rtl/sig_entry_hold.sv
module sig_entry_hold
  import sigreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_req,
  input  sig_entry_t load_entry,
  input  logic       out_ready,
  output logic       out_valid,
  output sig_entry_t out_entry,
  output logic       ovf
);
  logic release_now, accept, drop;
  assign release_now = out_valid && out_ready;
  assign accept      = load_req && (!out_valid || release_now);
  assign drop        = load_req && out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_entry <= '0;
      ovf       <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_entry <= load_entry;
      end else if (release_now) begin
        out_valid <= 1'b0;
      end
      if (drop) ovf <= 1'b1;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_entry));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load_req |=> !out_valid);
  p_overflow_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && out_valid && !out_ready |=> ovf);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_take_on_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && out_valid && out_ready |=> out_valid && out_entry == $past(load_entry));
endmodule

// File: rtl/sig_event_decoder.sv
module sig_event_decoder
  import sigreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [15:0]       wr_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [15:0]       evt_word,
  output logic [2:0]        evt_kind,
  output logic [5:0]        evt_user_code,
  output logic [7:0]        evt_sender,
  output logic              ovf_flag
);
  logic       hit;
  sig_entry_t dec_entry, held;

  sig_addr_match #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_match (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .hit(hit));

  sig_word_decode u_dec (.word(wr_data), .entry(dec_entry));

  sig_entry_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load_req(hit), .load_entry(dec_entry),
    .out_ready(evt_ready), .out_valid(evt_valid), .out_entry(held),
    .ovf(ovf_flag));

  assign evt_word      = held.word;
  assign evt_kind      = held.kind;
  assign evt_user_code = held.ucode;
  assign evt_sender    = held.word[LA_W-1:0];

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !evt_valid |=> !evt_valid);
  p_response_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ((evt_kind == 3'd0) == !evt_word[15]));
  p_user_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind != 3'd4 |-> evt_user_code == 6'd0);
  p_kind_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_kind <= 3'd5);
endmodule

// File: tb/test_sig_event_decoder.sv
module test_sig_event_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, evt_ready = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        evt_valid, ovf_flag;
  logic [15:0] evt_word;
  logic [2:0]  evt_kind;
  logic [5:0]  evt_user_code;
  logic [7:0]  evt_sender;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_event_decoder i_sig_event_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_wide(wr_wide), .wr_data(wr_data), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_word(evt_word), .evt_kind(evt_kind),
    .evt_user_code(evt_user_code), .evt_sender(evt_sender),
    .ovf_flag(ovf_flag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_kind(input logic [15:0] w);
    if (!w[15])              return 3'd0;
    else if (w[15:8] == 8'hFF) return 3'd1;
    else if (w[15:8] == 8'hFD) return 3'd2;
    else if (w[15:8] == 8'hFC) return 3'd3;
    else if (!w[14])         return 3'd4;
    else                     return 3'd5;
  endfunction

  task automatic do_write(input logic [5:0] a, input logic wide, input logic [15:0] d,
                          input logic rdy);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_wide = wide; wr_data = d; evt_ready = rdy;
    @(negedge clk);
    wr_en = 1'b0; evt_ready = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", evt_valid, 0);
    chk("R1 ovf", ovf_flag, 0);
    rst_n = 1'b1;

    // R4 R5 R6 R7 R8 R3 R9: sweep every upper byte
    for (int hi = 0; hi < 256; hi++) begin
      logic [15:0] w;
      logic [2:0]  k;
      w = {hi[7:0], hi[7:0] ^ 8'h5A};
      k = exp_kind(w);
      do_write(6'd8, 1'b1, w, 1'b0);
      chk("R3 valid", evt_valid, 1);
      chk("R3 word", evt_word, w);
      chk("R4/R5/R7 kind", evt_kind, k);
      chk("R6 user code", evt_user_code, (k == 3'd4) ? w[13:8] : 6'd0);
      chk("R8 sender", evt_sender, w[7:0]);
      @(negedge clk);
      chk("R3 hold", {evt_valid, evt_word}, {1'b1, w});
      do_ack();
      chk("R9 release", evt_valid, 0);
    end

    // R2: sweep offsets and widths
    for (int a = 0; a < 64; a++) begin
      for (int wd = 0; wd < 2; wd++) begin
        logic hit;
        hit = (a == 8) && (wd == 1);
        do_write(a[5:0], wd[0], 16'h1234 ^ 16'(a), 1'b0);
        chk("R2 decode", evt_valid, hit);
        if (hit) begin
          chk("R2 word", evt_word, 16'h1234 ^ 16'(a));
          do_ack();
        end
      end
    end
    chk("R10 no ovf yet", ovf_flag, 0);

    // R10 overflow
    do_write(6'd8, 1'b1, 16'h8001, 1'b0);
    do_write(6'd8, 1'b1, 16'h0002, 1'b0);
    chk("R10 ovf set", ovf_flag, 1);
    chk("R10 word kept", evt_word, 16'h8001);
    do_ack();
    chk("R10 sticky", ovf_flag, 1);
    chk("R9 released", evt_valid, 0);

    // re-reset, then R11 same-cycle release
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ovf after reset", ovf_flag, 0);
    chk("R1 valid after reset", evt_valid, 0);
    rst_n = 1'b1;
    do_write(6'd8, 1'b1, 16'hFD33, 1'b0);
    do_write(6'd8, 1'b1, 16'h9A44, 1'b1);
    chk("R11 valid", evt_valid, 1);
    chk("R11 word", evt_word, 16'h9A44);
    chk("R11 kind", evt_kind, 3'd4);
    chk("R11 no ovf", ovf_flag, 0);

    finish_run();
  end
endmodule